// File: doc/BRIEF.md
# Cross-Clock Mailbox Register

This block carries one data word from a writer running on clock A to a reader running on clock B, next to a FIFO and without passing through it. The writer posts a word by raising its mailbox select during an enabled write. The word is held, and a flag tells both sides that the mailbox is occupied. The reader raises its own mailbox select during an enabled read to take the word. That read frees the mailbox again.

The occupancy flag has two owners. It is set from the clock A side and cleared from the clock B side. Each request crosses to the other domain as a toggle through a two-flop synchronizer. Each side sees its own copy of the flag in its own clock domain.

On the reader side, one output bus is shared. The mailbox select chooses between the mailbox word and the FIFO's data. A mailbox read never requests a FIFO pop.

Top module: `xclk_mailbox`

## Requirements
- R1: After reset, `mbx_free_a` and `mbx_free_b` are both 1, meaning the mailbox is empty.
- R2: A clock A rising edge with `a_wr_en`=1, `a_mb_sel`=1 and `mbx_free_a`=1 stores `a_din` and drives `mbx_free_a` to 0 from that edge.
- R3: A clock A write attempt while `mbx_free_a`=0 is ignored. The stored word is kept and is the one later shown to port B.
- R4: A clock A edge with `a_wr_en`=0 or `a_mb_sel`=0 leaves the mailbox empty. Both flags stay 1.
- R5: After an accepted write, `mbx_free_b` goes to 0 within four clock B edges.
- R6: A clock B rising edge with `b_rd_en`=1, `b_mb_sel`=1 and `mbx_free_b`=0 drives `mbx_free_b` to 1 from that edge. `mbx_free_a` then returns to 1 within four clock A edges.
- R7: A clock B mailbox read while `mbx_free_b`=1 has no effect. A word written later is still reported occupied and delivered.
- R8: With `b_out_en`=1, `b_dout` equals the mailbox word when `b_mb_sel`=1 and `fifo_dout` when `b_mb_sel`=0. With `b_out_en`=0, `b_dout` is all zeros.
- R9: `fifo_pop` is 1 exactly when `b_rd_en`=1 and `b_mb_sel`=0. A mailbox read never pops the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| clk_a | input | 1 | Writer clock |
| a_wr_en | input | 1 | Writer transfer enable |
| a_mb_sel | input | 1 | Writer mailbox select |
| a_din | input | W | Word to post |
| mbx_free_a | output | 1 | Mailbox empty, clock A domain |
| clk_b | input | 1 | Reader clock |
| b_rd_en | input | 1 | Reader transfer enable |
| b_mb_sel | input | 1 | Reader mailbox select; also steers `b_dout` |
| b_out_en | input | 1 | Reader output enable |
| fifo_dout | input | W | FIFO read data to be multiplexed |
| b_dout | output | W | Reader output bus |
| mbx_free_b | output | 1 | Mailbox empty, clock B domain |
| fifo_pop | output | 1 | FIFO pop request |

## Verification
The assertions assume that each port's controls change only away from that port's own rising edge. They also assume that clock A and clock B keep running, so a toggle sent across always arrives. The stimulus changes writer inputs on falling edges of clock A and reader inputs on falling edges of clock B. The two clocks run at unrelated periods. Each handshake is given only a bounded number of edges to complete before the bench flags it.

// File: rtl/xclk_mailbox.sv
module xclk_mailbox #(
  parameter int W = 36
) (
  input  logic         rst_n,
  input  logic         clk_a,
  input  logic         a_wr_en,
  input  logic         a_mb_sel,
  input  logic [W-1:0] a_din,
  output logic         mbx_free_a,
  input  logic         clk_b,
  input  logic         b_rd_en,
  input  logic         b_mb_sel,
  input  logic         b_out_en,
  input  logic [W-1:0] fifo_dout,
  output logic [W-1:0] b_dout,
  output logic         mbx_free_b,
  output logic         fifo_pop
);

  logic [W-1:0] mbx_q;
  logic         set_tgl, clr_tgl;
  logic [1:0]   clr_sync_a, set_sync_b;
  logic         a_take, b_take;

  assign mbx_free_a = (set_tgl == clr_sync_a[1]);
  assign mbx_free_b = (set_sync_b[1] == clr_tgl);
  assign a_take     = a_wr_en & a_mb_sel & mbx_free_a;
  assign b_take     = b_rd_en & b_mb_sel & ~mbx_free_b;

  always_ff @(posedge clk_a or negedge rst_n)
    if (!rst_n) begin
      set_tgl    <= 1'b0;
      clr_sync_a <= '0;
      mbx_q      <= '0;
    end else begin
      clr_sync_a <= {clr_sync_a[0], clr_tgl};
      if (a_take) begin
        set_tgl <= ~set_tgl;
        mbx_q   <= a_din;
      end
    end

  always_ff @(posedge clk_b or negedge rst_n)
    if (!rst_n) begin
      clr_tgl    <= 1'b0;
      set_sync_b <= '0;
    end else begin
      set_sync_b <= {set_sync_b[0], set_tgl};
      if (b_take) clr_tgl <= ~clr_tgl;
    end

  assign b_dout   = !b_out_en ? '0 : (b_mb_sel ? mbx_q : fifo_dout);
  assign fifo_pop = b_rd_en & ~b_mb_sel;

  // R2
  a_post_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_wr_en && a_mb_sel && mbx_free_a) |=> !mbx_free_a);

  // R3
  a_hold_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
    !mbx_free_a |=> $stable(mbx_q));

  // R6
  b_clear_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
    (b_rd_en && b_mb_sel && !mbx_free_b) |=> mbx_free_b);

  // R8
  b_quiet_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
    !b_out_en |-> (b_dout == '0));

  // R9
  b_nopop_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
    b_mb_sel |-> !fifo_pop);

endmodule

// File: tb/tb_xclk_mailbox.sv
module tb_xclk_mailbox;
  localparam int W = 36;

  logic rst_n = 0, clk_a = 0, clk_b = 0;
  logic a_wr_en = 0, a_mb_sel = 0, b_rd_en = 0, b_mb_sel = 0, b_out_en = 0;
  logic [W-1:0] a_din = '0, fifo_dout = '0;
  logic [W-1:0] b_dout;
  logic mbx_free_a, mbx_free_b, fifo_pop;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk_a = ~clk_a;
  always #5.5 clk_b = ~clk_b;

  xclk_mailbox #(.W(W)) dut (.*);

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_write(input logic [W-1:0] d, input bit sel);
    @(negedge clk_a); a_wr_en = 1; a_mb_sel = sel; a_din = d;
    @(negedge clk_a); a_wr_en = 0; a_mb_sel = 0;
  endtask

  task automatic wait_b_full(output int n);
    n = 0;
    while (mbx_free_b && n < 10) begin @(negedge clk_b); n++; end
  endtask

  task automatic wait_a_free(output int n);
    n = 0;
    while (!mbx_free_a && n < 10) begin @(negedge clk_a); n++; end
  endtask

  task automatic b_read();
    @(negedge clk_b); b_rd_en = 1; b_mb_sel = 1;
    @(negedge clk_b); b_rd_en = 0;
  endtask

  function automatic logic [W-1:0] pat(input int i);
    return W'(64'(i) * 64'h9E37_79B9 + 64'(i) * 7 + 1);
  endfunction

  initial begin
    int n;
    b_out_en = 1;
    repeat (3) @(negedge clk_a);
    chk(mbx_free_a === 1, "R1 free_a", W'(mbx_free_a), 1);
    chk(mbx_free_b === 1, "R1 free_b", W'(mbx_free_b), 1);
    rst_n = 1;
    repeat (2) @(negedge clk_a);

    a_write(pat(99), 0);
    @(negedge clk_a); a_wr_en = 0; a_mb_sel = 1; a_din = pat(98);
    @(negedge clk_a); a_mb_sel = 0;
    repeat (6) @(negedge clk_b);
    chk(mbx_free_a === 1, "R4 free_a", W'(mbx_free_a), 1);
    chk(mbx_free_b === 1, "R4 free_b", W'(mbx_free_b), 1);

    for (int i = 0; i < 12; i++) begin
      a_write(pat(i), 1);
      chk(mbx_free_a === 0, "R2 free_a low", W'(mbx_free_a), 0);
      a_write(~pat(i), 1);
      wait_b_full(n);
      chk(n <= 4, "R5 free_b latency", W'(n), 4);
      b_mb_sel = 1;
      #1 chk(b_dout === pat(i), "R3 word kept", b_dout, pat(i));
      chk(fifo_pop === 0, "R9 no pop on mailbox", W'(fifo_pop), 0);
      b_read();
      chk(mbx_free_b === 1, "R6 free_b high", W'(mbx_free_b), 1);
      b_mb_sel = 0;
      wait_a_free(n);
      chk(n <= 4, "R6 free_a latency", W'(n), 4);
    end

    @(negedge clk_b); b_rd_en = 1; b_mb_sel = 1;
    repeat (3) @(negedge clk_b);
    b_rd_en = 0; b_mb_sel = 0;
    a_write(pat(50), 1);
    wait_b_full(n);
    chk(n <= 4 && mbx_free_b === 0, "R7 still delivered", W'(mbx_free_b), 0);

    for (int oe = 0; oe < 2; oe++)
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 4; k++) begin
          logic [W-1:0] exp;
          @(negedge clk_b);
          b_out_en = oe[0]; b_mb_sel = s[0]; fifo_dout = pat(200 + k);
          exp = !oe[0] ? '0 : (s[0] ? pat(50) : pat(200 + k));
          #1 chk(b_dout === exp, "R8 output mux", b_dout, exp);
        end
    b_out_en = 1;
    b_read();
    chk(mbx_free_b === 1, "R6 second clear", W'(mbx_free_b), 1);

    for (int r = 0; r < 2; r++)
      for (int s = 0; s < 2; s++) begin
        @(negedge clk_b); b_rd_en = r[0]; b_mb_sel = s[0];
        #1 chk(fifo_pop === (r[0] & ~s[0]), "R9 pop", W'(fifo_pop), W'(r[0] & ~s[0]));
      end
    b_rd_en = 0; b_mb_sel = 0;
    repeat (4) @(negedge clk_b);
    chk(mbx_free_b === 1, "R7 empty read ignored", W'(mbx_free_b), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule